// File: doc/BRIEF.md
# Counter-Array Capture/Compare Channel

This block is a single channel that sits beside a shared free-running counter. It receives the counter value as a bus and acts on it in one of several ways chosen by an 8-bit mode register.

- **Capture:** it latches the counter when an external input changes level.
- **Match:** it raises a flag when the counter reaches a programmed compare value. It can also flip its output pin on each match.
- **PWM:** it drives a pulse-width-modulated waveform whose duty is set by the compare register.
- **Frequency output:** it toggles the pin and advances its own match point by a programmed half period on every match.

Software programs the mode register, a 2-bit PWM width field and the 16-bit capture/compare register through write strobes. The current values of these registers are always visible on read-back outputs. The channel flag stays set until software writes a zero to it. An interrupt request follows the flag when the enable bit in the mode register allows it.

Top module: `cc_channel`

## Requirements
- R1: While reset is asserted, and until the first write, the output pin, flag, interrupt request, mode read-back, width read-back and compare register all read 0.
- R2: A mode write loads the mode byte and the 2-bit width field together. Both read back unchanged on the next cycle. The mode byte's bits, from bit 7 to bit 0, are:
  - bit 7: 16-bit PWM select
  - bit 6: comparator enable
  - bit 5: rising-edge capture enable
  - bit 4: falling-edge capture enable
  - bit 3: match-flag enable
  - bit 2: toggle enable
  - bit 1: PWM enable
  - bit 0: interrupt enable
- R3: The capture input passes through two synchronizing flops. A rising edge (when bit 5 is set) or a falling edge (when bit 4 is set) copies the counter value at the detecting clock edge into the compare register and sets the flag. With both bits set, every edge captures. The capture happens at the second clock edge after the one that first samples the new input level.
- R4: When a capture and a compare-register write fall in the same cycle, the captured counter value is kept and the write is lost.
- R5: With bits 6 and 3 set and PWM off, the flag is set on the edge where the counter equals the compare register.
- R6: With bits 6 and 2 set and PWM off, each counter match inverts the output pin.
- R7: With bits 6 and 1 set, bit 2 clear and bit 7 clear, the pin is driven high when the counter's low N bits are below the compare register's low N bits, and low otherwise. N = 8 + width field (8 to 11). The pin is updated one cycle after the counter value it reflects.
- R8: With bit 7 also set, the same PWM comparison uses all 16 bits.
- R9: With bits 6, 2 and 1 all set (frequency output), a match of the counter's low byte with the compare register's low byte does two things: it inverts the pin, and it replaces the low byte with the low byte plus the high byte (modulo 256).
- R10: The flag is cleared only by a flag write with data 0. A hardware set in the same cycle wins over that clear.
- R11: The interrupt request equals the flag while bit 0 is 1, and is held low while bit 0 is 0.
- R12: With bit 6 clear, no match, toggle, PWM or frequency-output activity takes place: the pin holds and no match sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Shared counter value |
| cap_in | input | 1 | External capture input (asynchronous) |
| mode_wr | input | 1 | Mode and width write strobe |
| mode_wdata | input | 8 | Mode byte to write |
| width_wdata | input | 2 | PWM width field to write |
| ccr_wr | input | 1 | Compare register write strobe |
| ccr_wdata | input | 16 | Compare register write data |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write data (0 clears) |
| ch_out | output | 1 | Channel output pin |
| ch_flag | output | 1 | Capture/compare flag |
| irq | output | 1 | Interrupt request |
| mode_q | output | 8 | Mode register read-back |
| width_q | output | 2 | Width field read-back |
| ccr_q | output | 16 | Compare register read-back |

## Verification
Two collisions are forced on purpose. In the first, a match sets the flag in the same cycle that software writes a zero to it. The bench places the counter exactly on the compare value while pulsing the clear, and expects the flag to remain 1. In the second, a capture edge lands in the cycle of a compare-register write. The bench counts the two synchronizer stages so that the strobe meets the detecting edge, then expects the counter value rather than the written data. A behavioural model predicts the pin, flag, request and all read-backs, and is compared against the block at every clock.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef struct packed {
    logic wide16;
    logic cmp_en;
    logic cap_rise;
    logic cap_fall;
    logic match_en;
    logic tog_en;
    logic pwm_en;
    logic irq_en;
  } cc_mode_t;
endpackage

// File: rtl/cc_edge_det.sv
module cc_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/cc_cmp_unit.sv
module cc_cmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0]   cnt,
  input  logic [CNT_W-1:0]   ccr,
  input  logic               cmp_en,
  input  logic               pwm_en,
  input  logic               tog_en,
  output logic               hit,
  output logic               freq_mode,
  output logic               pwm_mode,
  output logic [CNT_W/2-1:0] step_lo
);
  localparam int LO_W = CNT_W / 2;

  always_comb begin
    freq_mode = cmp_en & pwm_en & tog_en;
    pwm_mode  = cmp_en & pwm_en & ~tog_en;
    if (freq_mode) hit = (cnt[LO_W-1:0] == ccr[LO_W-1:0]);
    else           hit = cmp_en & ~pwm_en & (cnt == ccr);
    step_lo = ccr[LO_W-1:0] + ccr[CNT_W-1:CNT_W-LO_W];
  end
endmodule

// File: rtl/cc_pwm_level.sv
module cc_pwm_level #(
  parameter int CNT_W     = 16,
  parameter int PWM_MIN_W = 8,
  parameter int WSEL_W    = 2
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  ccr,
  input  logic              wide,
  input  logic [WSEL_W-1:0] width,
  output logic              level
);
  logic [CNT_W-1:0] mask;

  always_comb begin
    if (wide) mask = '1;
    else      mask = (CNT_W'(1) << (PWM_MIN_W + int'(width))) - CNT_W'(1);
    level = (cnt & mask) < (ccr & mask);
  end
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int WSEL_W      = 2,
  parameter int PWM_MIN_W   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cap_in,
  input  logic              mode_wr,
  input  logic [7:0]        mode_wdata,
  input  logic [WSEL_W-1:0] width_wdata,
  input  logic              ccr_wr,
  input  logic [CNT_W-1:0]  ccr_wdata,
  input  logic              flag_wr,
  input  logic              flag_wdata,
  output logic              ch_out,
  output logic              ch_flag,
  output logic              irq,
  output logic [7:0]        mode_q,
  output logic [WSEL_W-1:0] width_q,
  output logic [CNT_W-1:0]  ccr_q
);
  localparam int LO_W = CNT_W / 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  cc_mode_t          mode_r, mode_d;
  logic [WSEL_W-1:0] width_r, width_d;
  logic [CNT_W-1:0]  ccr_r, ccr_d;
  logic              out_r, out_d;
  logic              flag_r, flag_d;

  logic            rise, fall, cap_evt;
  logic            hit, freq_mode, pwm_mode, pwm_level;
  logic [LO_W-1:0] step_lo;

  cc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .din(cap_in), .rise(rise), .fall(fall)
  );

  cc_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
    .cnt(cnt_val), .ccr(ccr_r), .cmp_en(mode_r.cmp_en), .pwm_en(mode_r.pwm_en),
    .tog_en(mode_r.tog_en), .hit(hit), .freq_mode(freq_mode),
    .pwm_mode(pwm_mode), .step_lo(step_lo)
  );

  cc_pwm_level #(.CNT_W(CNT_W), .PWM_MIN_W(PWM_MIN_W), .WSEL_W(WSEL_W)) u_pwm (
    .cnt(cnt_val), .ccr(ccr_r), .wide(mode_r.wide16), .width(width_r),
    .level(pwm_level)
  );

  assign cap_evt = (rise & mode_r.cap_rise) | (fall & mode_r.cap_fall);

  always_comb begin
    mode_d  = mode_r;
    width_d = width_r;
    ccr_d   = ccr_r;
    out_d   = out_r;
    flag_d  = flag_r;
    if (mode_wr) begin
      mode_d  = cc_mode_t'(mode_wdata);
      width_d = width_wdata;
    end
    if (cap_evt)                ccr_d = cnt_val;
    else if (hit && freq_mode)  ccr_d[LO_W-1:0] = step_lo;
    else if (ccr_wr)            ccr_d = ccr_wdata;
    if (pwm_mode)                   out_d = pwm_level;
    else if (hit && mode_r.tog_en)  out_d = ~out_r;
    if (cap_evt || (hit && mode_r.match_en)) flag_d = 1'b1;
    else if (flag_wr && !flag_wdata)         flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_r  <= '0;
      width_r <= '0;
      ccr_r   <= '0;
      out_r   <= 1'b0;
      flag_r  <= 1'b0;
    end else begin
      mode_r  <= mode_d;
      width_r <= width_d;
      ccr_r   <= ccr_d;
      out_r   <= out_d;
      flag_r  <= flag_d;
    end
  end

  assign ch_out  = out_r;
  assign ch_flag = flag_r;
  assign irq     = flag_r & mode_r.irq_en;
  assign mode_q  = mode_r;
  assign width_q = width_r;
  assign ccr_q   = ccr_r;

  // R3
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (ch_flag && ccr_q == $past(cnt_val)));

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_r.tog_en && !mode_r.pwm_en) |=> (ch_out != $past(ch_out)));

  // R9
  freq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && freq_mode && !cap_evt) |=>
      (ccr_q[LO_W-1:0] == $past(ccr_q[LO_W-1:0] + ccr_q[CNT_W-1:LO_W])));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_flag && !(flag_wr && !flag_wdata)) |=> ch_flag);

  // R12
  cmp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[6] |=> $stable(ch_out));
endmodule

// File: tb/cc_channel_tb_top.sv
module cc_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_val = '0;
  logic        cap_in = 1'b0;
  logic        mode_wr = 1'b0;
  logic [7:0]  mode_wdata = '0;
  logic [1:0]  width_wdata = '0;
  logic        ccr_wr = 1'b0;
  logic [15:0] ccr_wdata = '0;
  logic        flag_wr = 1'b0;
  logic        flag_wdata = 1'b0;
  logic        ch_out, ch_flag, irq;
  logic [7:0]  mode_q;
  logic [1:0]  width_q;
  logic [15:0] ccr_q;

  always #10 clk = ~clk;

  cc_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cap_in(cap_in),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .width_wdata(width_wdata),
    .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .ch_out(ch_out), .ch_flag(ch_flag), .irq(irq),
    .mode_q(mode_q), .width_q(width_q), .ccr_q(ccr_q)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cnt_step = 0;
  bit    done = 0;
  string phase = "R1 reset";

  // reference model state
  int m_mode = 0, m_width = 0, m_ccr = 0, m_out = 0, m_flag = 0;
  int hist[$];

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("ch_out", int'(ch_out), m_out);
    check("ch_flag", int'(ch_flag), m_flag);
    check("irq (R11)", int'(irq), m_flag & m_mode & 1);
    check("mode_q (R2)", int'(mode_q), m_mode);
    check("width_q (R2)", int'(width_q), m_width);
    check("ccr_q", int'(ccr_q), m_ccr);
  endtask

  task automatic model_edge();
    int cmp, pwm, tog, freq, pwmm, hit, cap, nb, mask, c, s2, s3;
    int n_mode, n_width, n_ccr, n_out, n_flag;
    c = int'(cnt_val);
    cmp = (m_mode >> 6) & 1; pwm = (m_mode >> 1) & 1; tog = (m_mode >> 2) & 1;
    freq = cmp & pwm & tog;
    pwmm = cmp & pwm & (1 - tog);
    if (freq != 0) hit = ((c & 255) == (m_ccr & 255)) ? 1 : 0;
    else hit = (cmp != 0 && pwm == 0 && c == m_ccr) ? 1 : 0;
    s2 = hist[1]; s3 = hist[2];
    cap = ((s2 == 1 && s3 == 0 && ((m_mode >> 5) & 1) == 1) ||
           (s2 == 0 && s3 == 1 && ((m_mode >> 4) & 1) == 1)) ? 1 : 0;
    n_mode = m_mode; n_width = m_width; n_ccr = m_ccr; n_out = m_out; n_flag = m_flag;
    if (mode_wr) begin n_mode = int'(mode_wdata); n_width = int'(width_wdata); end
    if (cap != 0) n_ccr = c;
    else if (freq != 0 && hit != 0)
      n_ccr = (m_ccr & 16'hff00) | (((m_ccr & 255) + (m_ccr >> 8)) & 255);
    else if (ccr_wr) n_ccr = int'(ccr_wdata);
    if (pwmm != 0) begin
      nb = (((m_mode >> 7) & 1) != 0) ? 16 : 8 + m_width;
      mask = (1 << nb) - 1;
      n_out = ((c & mask) < (m_ccr & mask)) ? 1 : 0;
    end else if (hit != 0 && tog != 0) n_out = 1 - m_out;
    if (cap != 0 || (hit != 0 && ((m_mode >> 3) & 1) != 0)) n_flag = 1;
    else if (flag_wr && !flag_wdata) n_flag = 0;
    m_mode = n_mode; m_width = n_width; m_ccr = n_ccr; m_out = n_out; m_flag = n_flag;
    hist.push_front(int'(cap_in));
    void'(hist.pop_back());
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    compare_all();
    mode_wr = 1'b0; ccr_wr = 1'b0; flag_wr = 1'b0;
    cnt_val = cnt_val + 16'(cnt_step);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_mode(logic [7:0] m, logic [1:0] w);
    mode_wr = 1'b1; mode_wdata = m; width_wdata = w;
    tick();
  endtask

  task automatic set_ccr(logic [15:0] v);
    ccr_wr = 1'b1; ccr_wdata = v;
    tick();
  endtask

  task automatic clear_flag();
    flag_wr = 1'b1; flag_wdata = 1'b0;
    tick();
  endtask

  initial begin
    hist = '{0, 0, 0};
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    compare_all();
    rst_n = 1'b1;
    run(4);

    // R2 readback and R5/R6 match with toggle, counter free running
    phase = "R5 R6 match toggle";
    cnt_step = 1;
    set_ccr(16'h0040);
    set_mode(8'h4C, 2'd1);
    run(300);
    // R10: hardware set collides with software clear
    phase = "R10 clear vs match";
    cnt_step = 0;
    clear_flag();
    run(2);
    cnt_val = 16'h0040;
    flag_wr = 1'b1; flag_wdata = 1'b0;
    tick();
    cnt_val = 16'h0041;
    run(2);
    flag_wr = 1'b1; flag_wdata = 1'b1;   // writing 1 leaves flag as is
    tick();
    clear_flag();
    run(2);

    // R11: interrupt enable masking
    phase = "R11 irq enable";
    set_mode(8'h4D, 2'd0);
    cnt_val = 16'h0040;
    run(2);
    set_mode(8'h4C, 2'd0);
    run(2);
    clear_flag();

    // R3: capture on rising, falling, both
    phase = "R3 capture";
    cnt_step = 3;
    set_mode(8'h20, 2'd0);
    for (int k = 0; k < 6; k++) begin
      cap_in = ~cap_in; run(5);
      clear_flag(); run(2);
    end
    set_mode(8'h10, 2'd0);
    for (int k = 0; k < 6; k++) begin
      cap_in = ~cap_in; run(4);
      clear_flag();
    end
    set_mode(8'h30, 2'd0);
    for (int k = 0; k < 8; k++) begin
      cap_in = ~cap_in; run(3 + k);
    end
    // R4: capture meets a compare-register write
    phase = "R4 capture vs write";
    cap_in = ~cap_in;
    tick();
    tick();
    ccr_wr = 1'b1; ccr_wdata = 16'hBEEF;
    tick();
    run(3);
    clear_flag();
    cap_in = ~cap_in;
    run(1);                 // glitch shorter than the synchronizer still seen once
    cap_in = ~cap_in;
    run(6);

    // R7: PWM 8 to 11 bits
    phase = "R7 pwm 8-bit";
    set_mode(8'h00, 2'd0);
    clear_flag();
    cnt_step = 1; cnt_val = '0;
    set_ccr(16'h1280);
    set_mode(8'h42, 2'd0);
    run(520);
    phase = "R7 pwm 11-bit";
    set_mode(8'h42, 2'd3);
    set_ccr(16'h0300);
    run(2100);
    phase = "R7 pwm 10-bit zero duty";
    set_mode(8'h42, 2'd2);
    set_ccr(16'h0400);
    run(300);

    // R8: 16-bit PWM
    phase = "R8 pwm 16-bit";
    cnt_step = 97;
    set_ccr(16'h4000);
    set_mode(8'hC2, 2'd0);
    run(1400);

    // R9: frequency output
    phase = "R9 freq out";
    cnt_step = 1;
    set_mode(8'h00, 2'd0);
    set_ccr(16'h2010);
    set_mode(8'h4E, 2'd0);
    run(600);
    set_ccr(16'h0705);
    run(300);

    // R12: comparator disabled
    phase = "R12 cmp off";
    set_mode(8'h0E, 2'd0);
    clear_flag();
    set_ccr(16'h0010);
    run(400);
    set_mode(8'h0C, 2'd0);
    run(300);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule